// File: doc/BRIEF.md
# Port Credit Refill Manager

This block keeps the enqueue credits of several producer ports that all draw on one shared credit pool. Every port holds a local credit count and spends one credit on each enqueue it is allowed to make. When a port's count falls to its low watermark, the block moves a fixed quantum of credits from the pool into the port. Credits go back to the pool when the downstream logic reports that events have been scheduled out or released.

Each port's share follows from its configured enqueue depth. The depth is also the port's high watermark. The refill quantum is half of that depth, and the low watermark is the smaller of 16 and the quantum. A start pulse fills every port to its high watermark, takes those credits from the pool and enables the block.

The enqueue interface is valid/ready, one pair for each port. Ready does not depend on valid. A request seen with ready low is rejected, not held: the block keeps nothing, and the requester may retry or withdraw. A cycle with both valid and ready high spends one credit. Credit returns have no back-pressure: `ret_count` is added to the pool on every cycle in which `ret_valid` is high.

Top module: `credit_refill_mgr`

## Requirements
- R1: While reset is active, and after it until the first start pulse, every port count and the pool level read 0, `running` is low and no enqueue is ready.
- R2: A start pulse sets each port count to its configured depth and sets the pool to the pool size minus the sum of all depths, both visible on the next cycle, and raises `running`. Example: four ports of depth 32 with a pool of 4096 leave 3968 in the pool. Software must keep the pool size at or above the sum of the depths.
- R3: `enq_ready[i]` is high exactly when `running` is high, no start pulse is present and port i's count is nonzero. An accepted enqueue lowers that count by one on the next cycle.
- R4: A port with zero credits shows ready low. Its request is rejected, and its count stays at 0 unless that port is granted a refill.
- R5: Port i's refill quantum is floor(depth/2), and its low watermark is min(16, quantum).
- R6: A port is eligible for a refill when `running` is high, no start pulse is present, the quantum is nonzero, the count is at or below the low watermark, count plus quantum does not exceed the depth, and the pool holds at least one quantum. A granted refill adds the quantum to the port and takes it from the pool on the next cycle.
- R7: If the pool holds less than a port's quantum, that port gets no refill at all, not even a partial one.
- R8: At most one refill is granted per cycle. Eligible ports are served round-robin, starting at the port after the one last granted, with port 0 first after reset.
- R9: When `ret_valid` is high, `ret_count` is added to the pool on the next cycle, together with any refill taken from the pool in the same cycle.
- R10: The pool level, plus the sum of all port counts, plus the enqueues accepted but not yet returned, always equals the configured pool size.
- R11: While running, no port count exceeds that port's depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that prefills the ports and enables the block |
| cfg_pool_size | input | POOL_W | Total credits in the shared pool |
| cfg_depth | input | NUM_PORTS*CNT_W | Enqueue depth for each port, port 0 in the low bits |
| enq_valid | input | NUM_PORTS | Enqueue request for each port |
| enq_ready | output | NUM_PORTS | Credit available; valid and ready together accept the enqueue |
| ret_valid | input | 1 | Credit return present this cycle |
| ret_count | input | RET_W | Number of credits returned to the pool |
| pool_level | output | POOL_W | Credits currently held in the pool |
| port_credit | output | NUM_PORTS*CNT_W | Local credit count for each port, port 0 in the low bits |
| running | output | 1 | High after the first start pulse |

## Verification
A wrong port count shows up on the same cycle as a wrong `enq_ready` level, and one cycle after the faulty update as a mismatch on `port_credit`. A lost or duplicated credit breaks the conservation sum at once, because the bench recomputes that sum every cycle from its own count of accepted and returned credits. An arbitration fault, such as a wrong pointer or two grants in one cycle, changes which port's count jumps by a quantum, and this is visible one cycle after the grant.

// File: rtl/crm_pkg.sv
package crm_pkg;
  // ceiling applied to the low watermark of every port
  parameter int unsigned LWM_CEIL = 16;
endpackage

// File: rtl/crm_rr_arb.sv
module crm_rr_arb #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] req,
  output logic [NUM_PORTS-1:0] grant
);
  localparam int PTR_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    grant = '0;
    ptr_d = ptr_q;
    for (int k = NUM_PORTS - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(ptr_q) + k) % NUM_PORTS;
      if (req[idx]) begin
        grant = '0;
        grant[idx] = 1'b1;
        ptr_d = PTR_W'((idx + 1) % NUM_PORTS);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8
  grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/crm_port_slot.sv
module crm_port_slot #(
  parameter int CNT_W   = 11,
  parameter int LWM_CAP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             running,
  input  logic [CNT_W-1:0] depth,
  input  logic             enq_valid,
  input  logic             grant,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] quantum,
  output logic             enq_ready,
  output logic             refill_want
);
  logic [CNT_W-1:0] lwm;
  logic [CNT_W:0]   after_fill;
  logic [CNT_W:0]   count_d;
  logic             take;

  always_comb begin
    quantum    = depth >> 1;
    lwm        = (quantum < CNT_W'(LWM_CAP)) ? quantum : CNT_W'(LWM_CAP);
    after_fill = {1'b0, count} + {1'b0, quantum};
    enq_ready  = running && !start && (count != '0);
    take       = enq_valid && enq_ready;
    refill_want = running && !start && (quantum != '0) && (count <= lwm)
                  && (after_fill <= {1'b0, depth});
    count_d = {1'b0, count} - (CNT_W+1)'(take)
              + (grant ? {1'b0, quantum} : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (start) count <= depth;
    else            count <= count_d[CNT_W-1:0];
  end

  // R11
  count_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |-> (count <= depth));

  // R3
  enq_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_ready && !grant && !start) |=> (count == $past(count) - 1'b1));

  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && count == '0 && !grant) |=> (count == '0));

  // R6
  refill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (count <= lwm && refill_want));
endmodule

// File: rtl/credit_refill_mgr.sv
module credit_refill_mgr #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 11,
  parameter int POOL_W    = 16,
  parameter int RET_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [POOL_W-1:0]          cfg_pool_size,
  input  logic [NUM_PORTS*CNT_W-1:0] cfg_depth,
  input  logic [NUM_PORTS-1:0]       enq_valid,
  output logic [NUM_PORTS-1:0]       enq_ready,
  input  logic                       ret_valid,
  input  logic [RET_W-1:0]           ret_count,
  output logic [POOL_W-1:0]          pool_level,
  output logic [NUM_PORTS*CNT_W-1:0] port_credit,
  output logic                       running
);
  localparam int SUM_W = CNT_W + $clog2(NUM_PORTS + 1);

  logic [POOL_W-1:0]    pool_q;
  logic                 run_q;
  logic [NUM_PORTS-1:0] want, req, grant;
  logic [CNT_W-1:0]     quant [NUM_PORTS];
  logic [CNT_W-1:0]     granted_q;
  logic [SUM_W-1:0]     depth_sum;
  logic [POOL_W:0]      pool_d;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_slot
    crm_port_slot #(
      .CNT_W   (CNT_W),
      .LWM_CAP (crm_pkg::LWM_CEIL)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .running     (run_q),
      .depth       (cfg_depth[i*CNT_W +: CNT_W]),
      .enq_valid   (enq_valid[i]),
      .grant       (grant[i]),
      .count       (port_credit[i*CNT_W +: CNT_W]),
      .quantum     (quant[i]),
      .enq_ready   (enq_ready[i]),
      .refill_want (want[i])
    );
    assign req[i] = want[i] && ({{(POOL_W-CNT_W){1'b0}}, quant[i]} <= pool_q);
  end

  crm_rr_arb #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant)
  );

  always_comb begin
    granted_q = '0;
    depth_sum = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (grant[i]) granted_q = granted_q | quant[i];
      depth_sum = depth_sum + SUM_W'(cfg_depth[i*CNT_W +: CNT_W]);
    end
    pool_d = {1'b0, pool_q} - (POOL_W+1)'(granted_q)
             + (ret_valid ? (POOL_W+1)'(ret_count) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pool_q <= '0;
      run_q  <= 1'b0;
    end else if (start) begin
      pool_q <= cfg_pool_size - POOL_W'(depth_sum);
      run_q  <= 1'b1;
    end else begin
      pool_q <= pool_d[POOL_W-1:0];
    end
  end

  assign pool_level = pool_q;
  assign running    = run_q;

  // R7
  pool_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ({{(POOL_W-CNT_W){1'b0}}, granted_q} <= pool_q));

  // R9
  return_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start && ret_valid && grant == '0)
      |=> (pool_q == $past(pool_q) + POOL_W'($past(ret_count))));

  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> running);

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (enq_ready == '0 && grant == '0));
endmodule

// File: tb/credit_refill_mgr_tb.sv
module credit_refill_mgr_tb;
  localparam int N = 4;
  localparam int CW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [15:0]   cfg_pool_size = '0;
  logic [N*CW-1:0] cfg_depth = '0;
  logic [N-1:0]  enq_valid = '0;
  logic [N-1:0]  enq_ready;
  logic          ret_valid = 1'b0;
  logic [7:0]    ret_count = '0;
  logic [15:0]   pool_level;
  logic [N*CW-1:0] port_credit;
  logic          running;

  always #4 clk = ~clk;

  credit_refill_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_pool_size(cfg_pool_size),
    .cfg_depth(cfg_depth), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .ret_valid(ret_valid), .ret_count(ret_count), .pool_level(pool_level),
    .port_credit(port_credit), .running(running)
  );

  int checks = 0;
  int errors = 0;
  int m_cnt [N];
  int m_dep [N];
  int m_pool, m_size, m_ptr, inflight;
  bit m_run;

  // {enqueue mask, credits returned, cycles}
  localparam logic [19:0] VEC [10] = '{
    {4'b1111, 8'd0,  8'd6},
    {4'b0101, 8'd3,  8'd8},
    {4'b1010, 8'd0, 8'd10},
    {4'b1111, 8'd1, 8'd12},
    {4'b0000, 8'd20, 8'd4},
    {4'b0011, 8'd0, 8'd20},
    {4'b1100, 8'd2, 8'd15},
    {4'b1111, 8'd0, 8'd40},
    {4'b0000, 8'd9, 8'd20},
    {4'b1001, 8'd5, 8'd30}
  };

  function automatic int cnt_of(int i);
    return int'(port_credit[i*CW +: CW]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_state();
    int sum = 0;
    for (int i = 0; i < N; i++) begin
      chk(cnt_of(i) == m_cnt[i], "R6", cnt_of(i), m_cnt[i]);
      if (m_run) chk(cnt_of(i) <= m_dep[i], "R11", cnt_of(i), m_dep[i]);
      sum += cnt_of(i);
    end
    chk(int'(pool_level) == m_pool, "R9", int'(pool_level), m_pool);
    if (m_run)
      chk(int'(pool_level) + sum + inflight == m_size, "R10",
          int'(pool_level) + sum + inflight, m_size);
  endtask

  task automatic step(input logic [N-1:0] mask, input int ret);
    int r;
    int q, lwm;
    bit rdy [N];
    bit done = 0;
    r = (ret > inflight) ? inflight : ret;
    enq_valid = mask;
    ret_valid = (r != 0);
    ret_count = 8'(r);
    #1;
    for (int i = 0; i < N; i++) begin
      rdy[i] = m_run && (m_cnt[i] != 0);
      chk(enq_ready[i] == rdy[i], "R3", int'(enq_ready[i]), int'(rdy[i]));
    end
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (m_ptr + k) % N;
      q = m_dep[idx] / 2;
      lwm = (q < 16) ? q : 16;
      if (!done && m_run && q != 0 && m_cnt[idx] <= lwm &&
          m_cnt[idx] + q <= m_dep[idx] && m_pool >= q) begin
        done = 1;
        m_cnt[idx] += q;
        m_pool -= q;
        m_ptr = (idx + 1) % N;
      end
    end
    for (int i = 0; i < N; i++)
      if (mask[i] && rdy[i]) begin
        m_cnt[i] -= 1;
        inflight += 1;
      end
    m_pool += r;
    inflight -= r;
    @(posedge clk);
    #2;
    check_state();
    @(negedge clk);
    enq_valid = '0;
    ret_valid = 1'b0;
    ret_count = '0;
  endtask

  task automatic do_start(input int size, input int d0, input int d1, input int d2, input int d3);
    int sum;
    m_dep[0] = d0; m_dep[1] = d1; m_dep[2] = d2; m_dep[3] = d3;
    cfg_pool_size = 16'(size);
    cfg_depth = {CW'(d3), CW'(d2), CW'(d1), CW'(d0)};
    start = 1'b1;
    @(posedge clk);
    #2;
    start = 1'b0;
    sum = d0 + d1 + d2 + d3;
    for (int i = 0; i < N; i++) m_cnt[i] = m_dep[i];
    m_pool = size - sum;
    m_size = size;
    m_run = 1;
    inflight = 0;
    chk(running == 1'b1, "R2", int'(running), 1);
    check_state();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_dep[i] = 0; end
    m_pool = 0; m_size = 0; m_ptr = 0; inflight = 0; m_run = 0;
    repeat (3) @(negedge clk);
    // R1: state while in reset
    for (int i = 0; i < N; i++) chk(cnt_of(i) == 0, "R1", cnt_of(i), 0);
    chk(pool_level == 0, "R1", int'(pool_level), 0);
    rst_n = 1'b1;
    enq_valid = '1;
    #1;
    chk(enq_ready == '0, "R1", int'(enq_ready), 0);
    chk(running == 1'b0, "R1", int'(running), 0);
    @(negedge clk);
    chk(enq_ready == '0, "R1", int'(enq_ready), 0);
    enq_valid = '0;

    // R2: four ports of depth 32 out of 4096
    do_start(4096, 32, 32, 32, 32);
    chk(pool_level == 3968, "R2", int'(pool_level), 3968);
    chk(cnt_of(2) == 32, "R2", cnt_of(2), 32);

    // R7: pool of 1 cannot fund a quantum of 2
    do_start(17, 4, 4, 4, 4);
    step(4'b0001, 0);
    step(4'b0001, 0);
    step(4'b0000, 0);
    step(4'b0000, 0);
    chk(cnt_of(0) == 2, "R7", cnt_of(0), 2);
    chk(pool_level == 1, "R7", int'(pool_level), 1);
    step(4'b0000, 1);
    step(4'b0000, 0);
    chk(cnt_of(0) == 4, "R7", cnt_of(0), 4);
    chk(pool_level == 0, "R7", int'(pool_level), 0);

    // R8: ports 1 and 2 eligible together, port 1 served first
    step(4'b0110, 0);
    step(4'b0110, 0);
    step(4'b0000, 4);
    step(4'b0000, 0);
    chk(cnt_of(1) == 4, "R8", cnt_of(1), 4);
    chk(cnt_of(2) == 2, "R8", cnt_of(2), 2);
    step(4'b0000, 0);
    chk(cnt_of(2) == 4, "R8", cnt_of(2), 4);

    // R4: port 3 drained to zero, later requests rejected
    for (int k = 0; k < 4; k++) step(4'b1000, 0);
    chk(cnt_of(3) == 0, "R4", cnt_of(3), 0);
    step(4'b1000, 0);
    chk(enq_ready[3] == 1'b0, "R4", int'(enq_ready[3]), 0);
    step(4'b1000, 0);
    chk(cnt_of(3) == 0, "R4", cnt_of(3), 0);

    // R5: depth 8 gives quantum 4 and low watermark 4
    do_start(120, 32, 8, 16, 4);
    for (int k = 0; k < 3; k++) step(4'b0010, 0);
    chk(cnt_of(1) == 5, "R5", cnt_of(1), 5);
    step(4'b0010, 0);
    chk(cnt_of(1) == 4, "R5", cnt_of(1), 4);
    step(4'b0000, 0);
    chk(cnt_of(1) == 8, "R5", cnt_of(1), 8);

    // table walk: mixed enqueue and return patterns
    for (int v = 0; v < 10; v++)
      for (int r = 0; r < int'(VEC[v][7:0]); r++)
        step(VEC[v][19:16], int'(VEC[v][15:8]));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule